// File: doc/BRIEF.md
# Posted-CAS Additive Latency Scheduler

This block is the command timing core of a DDR2-style memory device model. On a single-data-rate command bus it takes row activates, column reads and column writes. It also takes a mode register write that carries an additive latency (AL) and a CAS latency (CL).

A read or write may be sent as early as the cycle after an activate, before the row-to-column delay has run out. The block holds each column command for AL cycles and then presents it as an internal column access. It then produces per-beat strobes for a four-beat burst. Read beats start AL+CL cycles after the external command. Write capture beats start one cycle earlier.

For every internal column access, the block checks whether the row-to-column delay of the target bank has elapsed. If it has not, it raises a violation flag in the same cycle as the access. With AL set to 0, commands pass straight through, as on a device without posted column commands.

Top module: `posted_cas_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, `col_valid`, `trcd_viol`, `rd_beat` and `wr_beat` are 0, `al_cur` is 0 and `cl_cur` is 3.
- R2: `cmd_op` encodes 2'b00 = no operation, 2'b01 = activate, 2'b10 = read and 2'b11 = write. A read or write sampled at clock edge E is accepted in any cycle, including right after an activate. It appears as `col_valid`=1 in the cycle that follows edge E+AL.
- R3: In that issue cycle, `col_write` is 1 for a write and 0 for a read, and `col_bank` equals the command's bank. Commands on consecutive cycles, or on any other spacing, are issued in order and keep their spacing.
- R4: A read sampled at edge E drives `rd_beat`=1 in the four cycles that follow edges E+AL+CL through E+AL+CL+3.
- R5: A write sampled at edge E drives `wr_beat`=1 in the four cycles that follow edges E+AL+CL-1 through E+AL+CL+2.
- R6: When bursts of the same kind overlap, the strobe stays high for the union of their beats, and no beat is lost.
- R7: `trcd_viol` is 1 in an issue cycle exactly when an activate of the same bank was sampled fewer than TRCD (default 3) edges before the issue edge E+AL, counting an activate sampled at the issue edge itself.
- R8: A mode write (`mr_we`=1) at edge E is refused when a read or write is sampled at E or at any of the previous AL_MAX+CL_MAX+3 (default 12) edges. A refused write leaves `al_cur` and `cl_cur` unchanged.
- R9: A mode write whose AL is above 4, or whose CL is outside 3..5, is refused as a whole, and the previous setting is kept. An accepted write shows on `al_cur` and `cl_cur` in the cycle after its edge, and it applies to commands sampled after that edge.
- R10: With TRCD=3 and CL=3, setting AL to 0, 1 and 2 gives first read beats 3, 4 and 5 cycles after the read command. The same settings give first write beats 2, 3 and 4 cycles after the write command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command code: nop, activate, read, write |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| mr_we | input | 1 | Mode register write request |
| mr_al | input | AL_W | Requested additive latency |
| mr_cl | input | CL_W | Requested CAS latency |
| col_valid | output | 1 | Internal column access issued this cycle |
| col_write | output | 1 | Issued access is a write |
| col_bank | output | BANK_W | Bank of the issued access |
| trcd_viol | output | 1 | Issued access breaks the row-to-column delay |
| rd_beat | output | 1 | Read data beat valid |
| wr_beat | output | 1 | Write data capture beat |
| al_cur | output | AL_W | Additive latency in force |
| cl_cur | output | CL_W | CAS latency in force |

## Verification
Two functions can fall in the same cycle at the issue edge. One is the internal release of a held column command. The other is a fresh activate of that command's bank, and it must count as a row-to-column violation. The bench provokes this with a read to a bank followed, inside the AL window, by an activate of that same bank. Random traffic with AL above 0 repeats the case across all banks. A reference model checks the verdict every cycle. It records the latest activate edge of each bank and compares the distance to the issue edge against TRCD.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_ACT = 2'b01,
    OP_RD  = 2'b10,
    OP_WR  = 2'b11
  } op_t;

  typedef struct packed {
    logic vld;
    logic wr;
  } slot_t;
endpackage

// File: rtl/psc_mode_reg.sv
module psc_mode_reg #(
  parameter int AL_W   = 3,
  parameter int CL_W   = 3,
  parameter int AL_MAX = 4,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AL_W-1:0] al_in,
  input  logic [CL_W-1:0] cl_in,
  input  logic            idle,
  output logic [AL_W-1:0] al_q,
  output logic [CL_W-1:0] cl_q
);
  logic in_range;

  always_comb begin
    in_range = (al_in <= AL_W'(AL_MAX)) &&
               (cl_in >= CL_W'(CL_MIN)) &&
               (cl_in <= CL_W'(CL_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      al_q <= '0;
      cl_q <= CL_W'(CL_MIN);
    end else if (we && in_range && idle) begin
      al_q <= al_in;
      cl_q <= cl_in;
    end
  end
endmodule

// File: rtl/psc_hold_pipe.sv
module psc_hold_pipe #(
  parameter int DEPTH  = 12,
  parameter int BANK_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_vld,
  input  logic                         in_wr,
  input  logic [BANK_W-1:0]            in_bank,
  output logic [DEPTH:0]               tap_vld,
  output logic [DEPTH:0]               tap_wr,
  output logic [DEPTH:0][BANK_W-1:0]   tap_bank,
  output logic                         busy
);
  psc_pkg::slot_t [DEPTH-1:0]          stg;
  logic [DEPTH-1:0][BANK_W-1:0]        stg_bank;

  // Valid/kind bits carry reset; bank field is pure shift (SRL friendly).
  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= '{vld: in_vld, wr: in_wr & in_vld};
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk) begin
    stg_bank[0] <= in_bank;
    for (int i = 1; i < DEPTH; i++) stg_bank[i] <= stg_bank[i-1];
  end

  // Tap 0 is the incoming command, tap k is the command accepted k edges ago.
  assign tap_vld[0]  = in_vld;
  assign tap_wr[0]   = in_wr & in_vld;
  assign tap_bank[0] = in_bank;

  genvar g;
  generate
    for (g = 1; g <= DEPTH; g++) begin : g_tap
      assign tap_vld[g]  = stg[g-1].vld;
      assign tap_wr[g]   = stg[g-1].wr;
      assign tap_bank[g] = stg_bank[g-1];
    end
  endgenerate

  always_comb begin
    busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) busy = busy | stg[i].vld;
  end
endmodule

// File: rtl/psc_trcd_track.sv
module psc_trcd_track #(
  parameter int BANK_W = 2,
  parameter int TRCD   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [BANK_W-1:0] chk_bank,
  output logic              early
);
  localparam int BANKS = 2 ** BANK_W;
  localparam int CNT_W = (TRCD > 1) ? $clog2(TRCD) : 1;

  logic [BANKS-1:0][CNT_W-1:0] remain;

  genvar g;
  generate
    for (g = 0; g < BANKS; g++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) begin
          remain[g] <= '0;
        end else if (act && (act_bank == BANK_W'(g))) begin
          remain[g] <= CNT_W'(TRCD - 1);
        end else if (remain[g] != '0) begin
          remain[g] <= remain[g] - 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    early = (remain[chk_bank] != '0) || (act && (act_bank == chk_bank));
  end
endmodule

// File: rtl/posted_cas_sched.sv
module posted_cas_sched #(
  parameter int AL_MAX = 4,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 5,
  parameter int BURST  = 4,
  parameter int TRCD   = 3,
  parameter int BANK_W = 2,
  localparam int AL_W  = $clog2(AL_MAX + 1),
  localparam int CL_W  = $clog2(CL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              mr_we,
  input  logic [AL_W-1:0]   mr_al,
  input  logic [CL_W-1:0]   mr_cl,
  output logic              col_valid,
  output logic              col_write,
  output logic [BANK_W-1:0] col_bank,
  output logic              trcd_viol,
  output logic              rd_beat,
  output logic              wr_beat,
  output logic [AL_W-1:0]   al_cur,
  output logic [CL_W-1:0]   cl_cur
);
  import psc_pkg::*;

  localparam int DEPTH = AL_MAX + CL_MAX + BURST - 1;
  localparam int IDX_W = $clog2(DEPTH + BURST + 1);

  op_t                       op;
  logic                      is_col, is_act, busy, early;
  logic [DEPTH:0]            tap_vld, tap_wr;
  logic [DEPTH:0][BANK_W-1:0] tap_bank;
  logic [IDX_W-1:0]          al_idx, rl_idx, wl_idx, ri, wi;
  logic                      iss_vld, iss_wr, rd_hit, wr_hit;
  logic [BANK_W-1:0]         iss_bank;

  assign op     = op_t'(cmd_op);
  assign is_col = (op == OP_RD) || (op == OP_WR);
  assign is_act = (op == OP_ACT);

  psc_mode_reg #(
    .AL_W(AL_W), .CL_W(CL_W), .AL_MAX(AL_MAX), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX)
  ) u_mode (
    .clk(clk), .rst(rst), .we(mr_we), .al_in(mr_al), .cl_in(mr_cl),
    .idle(~busy & ~is_col), .al_q(al_cur), .cl_q(cl_cur)
  );

  psc_hold_pipe #(.DEPTH(DEPTH), .BANK_W(BANK_W)) u_pipe (
    .clk(clk), .rst(rst), .in_vld(is_col), .in_wr(op == OP_WR),
    .in_bank(cmd_bank), .tap_vld(tap_vld), .tap_wr(tap_wr),
    .tap_bank(tap_bank), .busy(busy)
  );

  // Latency taps from the mode in force.
  always_comb begin
    al_idx = IDX_W'(al_cur);
    rl_idx = IDX_W'(al_cur) + IDX_W'(cl_cur);
    wl_idx = rl_idx - 1'b1;
  end

  always_comb begin
    iss_vld  = tap_vld[al_idx];
    iss_wr   = tap_wr[al_idx];
    iss_bank = tap_bank[al_idx];
  end

  psc_trcd_track #(.BANK_W(BANK_W), .TRCD(TRCD)) u_trcd (
    .clk(clk), .rst(rst), .act(is_act), .act_bank(cmd_bank),
    .chk_bank(iss_bank), .early(early)
  );

  // Burst strobes: OR of every command whose beat window covers this edge.
  always_comb begin
    rd_hit = 1'b0;
    wr_hit = 1'b0;
    ri     = '0;
    wi     = '0;
    for (int b = 0; b < BURST; b++) begin
      ri = rl_idx + IDX_W'(b);
      wi = wl_idx + IDX_W'(b);
      if (int'(ri) <= DEPTH) rd_hit = rd_hit | (tap_vld[ri] & ~tap_wr[ri]);
      if (int'(wi) <= DEPTH) wr_hit = wr_hit | (tap_vld[wi] & tap_wr[wi]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_valid <= 1'b0;
      col_write <= 1'b0;
      col_bank  <= '0;
      trcd_viol <= 1'b0;
      rd_beat   <= 1'b0;
      wr_beat   <= 1'b0;
    end else begin
      col_valid <= iss_vld;
      col_write <= iss_vld & iss_wr;
      col_bank  <= iss_bank;
      trcd_viol <= iss_vld & early;
      rd_beat   <= rd_hit;
      wr_beat   <= wr_hit;
    end
  end
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int AL_MAX = 4,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 5,
  parameter int AL_W   = 3,
  parameter int CL_W   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            col_valid,
  input logic            trcd_viol,
  input logic            rd_beat,
  input logic            wr_beat,
  input logic [AL_W-1:0] al_cur,
  input logic [CL_W-1:0] cl_cur
);
  // R7: the flag only accompanies an internal column access
  a_r7_viol_on_issue: assert property (@(posedge clk) disable iff (rst)
    trcd_viol |-> col_valid);

  // R4: a read strobe run never ends before four beats (default burst)
  a_r4_rd_four_beats: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_beat) |-> ($past(rd_beat, 2) && $past(rd_beat, 3) && $past(rd_beat, 4)));

  // R5: same for the write capture strobe
  a_r5_wr_four_beats: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_beat) |-> ($past(wr_beat, 2) && $past(wr_beat, 3) && $past(wr_beat, 4)));

  // R8: no mode change at an edge where a held command was released
  a_r8_mode_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    col_valid |-> ($stable(al_cur) && $stable(cl_cur)));

  // R9: the setting in force is always a supported one
  a_r9_mode_in_range: assert property (@(posedge clk) disable iff (rst)
    (al_cur <= AL_W'(AL_MAX)) && (cl_cur >= CL_W'(CL_MIN)) && (cl_cur <= CL_W'(CL_MAX)));
endmodule

bind posted_cas_sched psc_checker #(
  .AL_MAX(AL_MAX), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .AL_W(AL_W), .CL_W(CL_W)
) u_chk (
  .clk(clk), .rst(rst), .col_valid(col_valid), .trcd_viol(trcd_viol),
  .rd_beat(rd_beat), .wr_beat(wr_beat), .al_cur(al_cur), .cl_cur(cl_cur)
);

// File: tb/sim_posted_cas_sched.sv
module sim_posted_cas_sched;
  localparam int CLK_P = 10;
  localparam int NC    = 6000;
  localparam int TRCD  = 3;
  localparam int HOLD  = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd_op = 2'b00;
  logic [1:0] cmd_bank = '0;
  logic       mr_we = 1'b0;
  logic [2:0] mr_al = '0;
  logic [2:0] mr_cl = '0;
  logic       col_valid, col_write, trcd_viol, rd_beat, wr_beat;
  logic [1:0] col_bank;
  logic [2:0] al_cur, cl_cur;

  posted_cas_sched u0 (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .mr_we(mr_we), .mr_al(mr_al), .mr_cl(mr_cl),
    .col_valid(col_valid), .col_write(col_write), .col_bank(col_bank),
    .trcd_viol(trcd_viol), .rd_beat(rd_beat), .wr_beat(wr_beat),
    .al_cur(al_cur), .cl_cur(cl_cur)
  );

  always #(CLK_P/2) clk = ~clk;

  int ec = 0;
  always @(posedge clk) ec <= ec + 1;

  int n_chk = 0, n_fail = 0;
  bit ex_col[NC], ex_cwr[NC], ex_rd[NC], ex_wr[NC];
  int ex_cbk[NC];
  int last_act[4];
  int last_col = -100;
  int m_al = 0, m_cl = 3;
  int last_e = 0, probe_e0 = 0, first_rd = -1, first_wr = -1;
  bit checking = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, ec, act, exp);
    end
  endtask

  task automatic check_now();
    int n = ec;
    bit vexp;
    chk(col_valid === ex_col[n], "R2 column issue", int'(col_valid), int'(ex_col[n]));
    if (ex_col[n])
      chk(col_write === ex_cwr[n] && int'(col_bank) == ex_cbk[n], "R3 issue kind/bank",
          int'({col_write, col_bank}), int'(ex_cwr[n]) * 4 + ex_cbk[n]);
    chk(rd_beat === ex_rd[n], "R4,R6 read beat", int'(rd_beat), int'(ex_rd[n]));
    chk(wr_beat === ex_wr[n], "R5,R6 write beat", int'(wr_beat), int'(ex_wr[n]));
    vexp = ex_col[n] && ((n - last_act[ex_cbk[n]]) < TRCD);
    chk(trcd_viol === vexp, "R7 row-to-column flag", int'(trcd_viol), int'(vexp));
    chk(int'(al_cur) == m_al && int'(cl_cur) == m_cl, "R8,R9 mode in force",
        int'(al_cur) * 8 + int'(cl_cur), m_al * 8 + m_cl);
    if (rd_beat && first_rd < 0) first_rd = n - probe_e0;
    if (wr_beat && first_wr < 0) first_wr = n - probe_e0;
  endtask

  task automatic model_apply(input int e, input int op, input int bk, input bit mwe,
                             input int mal, input int mcl);
    bit col = (op >= 2);
    bit acc = mwe && mal <= 4 && mcl >= 3 && mcl <= 5 && !col && (e - last_col) > HOLD;
    if (op == 1) last_act[bk] = e;
    if (col) begin
      int i = e + m_al;
      int rl = m_al + m_cl;
      ex_col[i] = 1; ex_cwr[i] = (op == 3); ex_cbk[i] = bk;
      for (int b = 0; b < 4; b++) begin
        if (op == 2) ex_rd[e + rl + b] = 1;
        else         ex_wr[e + rl - 1 + b] = 1;
      end
      last_col = e;
    end
    if (acc) begin m_al = mal; m_cl = mcl; end
  endtask

  task automatic tick(input int op, input int bk, input bit mwe, input int mal, input int mcl);
    @(negedge clk);
    if (checking) check_now();
    cmd_op = 2'(op); cmd_bank = 2'(bk);
    mr_we = mwe; mr_al = 3'(mal); mr_cl = 3'(mcl);
    last_e = ec + 1;
    model_apply(last_e, op, bk, mwe, mal, mcl);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) tick(0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int b = 0; b < 4; b++) last_act[b] = -100;
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!col_valid && !trcd_viol && !rd_beat && !wr_beat, "R1 strobes in reset",
        int'({col_valid, trcd_viol, rd_beat, wr_beat}), 0);
    chk(al_cur == 0 && cl_cur == 3, "R1 mode in reset", int'(al_cur) * 8 + int'(cl_cur), 3);
    rst = 1'b0;
    last_e = ec + 1;
    checking = 1;
    idle(1);

    // R10: latency table for AL 0,1,2 with CL 3
    for (int a = 0; a < 3; a++) begin
      idle(14);
      tick(0, 0, 1, a, 3);
      idle(2);
      tick(1, 0, 0, 0, 0);
      tick(2, 0, 0, 0, 0);
      probe_e0 = last_e; first_rd = -1; first_wr = -1;
      idle(9);
      chk(first_rd == 3 + a, "R10 read latency", first_rd, 3 + a);
      tick(3, 1, 0, 0, 0);
      probe_e0 = last_e; first_rd = -1; first_wr = -1;
      idle(9);
      chk(first_wr == 2 + a, "R10 write latency", first_wr, 2 + a);
    end

    // R8: refused while busy or with a same-cycle column command
    idle(14);
    tick(0, 0, 1, 1, 4);
    tick(2, 1, 0, 0, 0);
    tick(0, 0, 1, 3, 5);
    tick(2, 2, 1, 2, 3);
    idle(2);
    chk(al_cur == 1 && cl_cur == 4, "R8 busy write refused", int'(al_cur) * 8 + int'(cl_cur), 12);

    // R9: out-of-range values refused
    idle(14);
    tick(0, 0, 1, 5, 3);
    tick(0, 0, 1, 2, 6);
    tick(0, 0, 1, 2, 2);
    idle(1);
    chk(al_cur == 1 && cl_cur == 4, "R9 bad values refused", int'(al_cur) * 8 + int'(cl_cur), 12);
    tick(0, 0, 1, 4, 5);
    idle(1);
    chk(al_cur == 4 && cl_cur == 5, "R9 max values taken", int'(al_cur) * 8 + int'(cl_cur), 37);

    // R3,R6: back-to-back mixed traffic at largest latency
    tick(2, 0, 0, 0, 0); tick(2, 1, 0, 0, 0); tick(3, 2, 0, 0, 0); tick(2, 3, 0, 0, 0);
    tick(3, 0, 0, 0, 0); tick(3, 1, 0, 0, 0); idle(1); tick(2, 2, 0, 0, 0);
    idle(16);

    // R7: activate landing in the hold window and on the issue edge
    tick(0, 0, 1, 2, 3);
    tick(1, 1, 0, 0, 0); tick(2, 1, 0, 0, 0);
    tick(2, 2, 0, 0, 0); tick(1, 2, 0, 0, 0);
    tick(2, 3, 0, 0, 0); idle(1); tick(1, 3, 0, 0, 0);
    idle(12);

    // Random traffic
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom % 100;
      if (r < 3) begin
        idle(14);
        tick(0, 0, 1, $urandom % 6, 2 + $urandom % 5);
      end else if (r < 6) begin
        tick(0, 0, 1, $urandom % 5, 3 + $urandom % 3);
      end else begin
        tick($urandom % 4, $urandom % 4, 0, 0, 0);
      end
    end
    idle(20);
    summary();
  end
endmodule